// File: doc/BRIEF.md
# Serial Port Interrupt Flag Generator

This block keeps the status flags of a UART-style serial port and turns them into two interrupt request lines. It follows the transmit holding register and the transmit shift register, latches the arrival of a received word, and records a wakeup event seen on the receive line. Each flag has its own enable bit and its own routing bit. The routing bit sends the flag to interrupt line 0 or line 1. Bit timing, baud generation and the DMA engine are outside the block; they drive its strobes.

Each line carries a registered priority encoder. The encoder reports a vector for the lowest-numbered pending source on that line, and reports 0 when nothing is pending. Source numbering is wakeup = bit 0 (vector 1), receive-ready = bit 1 (vector 2) and transmit-ready = bit 2 (vector 3). The same bit order applies to every per-source bus. The transmit interrupt is meant to be fed from its service routine. It stays silent after it is enabled until the first word has gone from the holding register into the shift register.

Top module: `sp_irq_flags`

## Requirements
- R1: After hardware reset, `txrdy`, `rxrdy`, `wake_flag`, all enables, `irq0`, `irq1`, `vec0` and `vec1` are 0, and `tx_empty` equals `shift_empty`.
- R2: `txrdy` becomes 1 one cycle after `shift_load` while the holding register is full. A `hold_wr` clears it one cycle later, and the write wins when both happen in the same cycle. `shift_load` with an empty holding register changes nothing.
- R3: `tx_empty` is 1 only when the holding register is empty and `shift_empty` is 1. The holding register is full from the cycle after a `hold_wr` until the cycle after the transfer.
- R4: Setting the transmit enable (`ien_set[2]`) while no transfer has taken place leaves both lines low. The first interrupt follows the first transfer.
- R5: The transmit source is pending only while `txrdy`, its enable and `!tx_dma_sel` all hold. Clearing the enable drops the request, and setting it again restores the request while `txrdy` is still 1.
- R6: `tx_enable` low clears `txrdy` and the holding register and ignores `hold_wr`. `soft_reset` high clears `txrdy`, the holding register, `rxrdy` and `wake_flag` and leaves the enables unchanged.
- R7: `rxrdy` is set by `rx_done` and cleared by `rx_read`, and the set wins. The receive source is pending only while `rxrdy`, its enable and both `rx_dma_sel` and `rx_dma_all_sel` low all hold.
- R8: `wake_flag` is set by `wake_evt` and cleared by `wake_clr`, and the set wins. The source is pending while the flag and its enable are 1.
- R9: A 1 on `ien_set[i]` sets enable i and a 1 on `ien_clr[i]` clears it. When both are 1, the clear wins.
- R10: `lvl_sel[i]` = 1 routes source i to line 1 and 0 routes it to line 0. Each line is high while any source routed to it is pending.
- R11: Each vector is 0 when its line has nothing pending. Otherwise it is the index plus one of the lowest-numbered pending source on that line. Lines and vectors are registered: they reflect the flag, enable, routing and DMA state of the previous cycle, which puts them two cycles after a flag event input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_reset | input | 1 | Synchronous flag flush |
| tx_enable | input | 1 | Transmitter enabled |
| ien_set | input | 3 | Write-1 set of per-source enables |
| ien_clr | input | 3 | Write-1 clear of per-source enables |
| lvl_sel | input | 3 | Per-source line select (1 = line 1) |
| tx_dma_sel | input | 1 | Transmit served by DMA |
| rx_dma_sel | input | 1 | Receive served by DMA |
| rx_dma_all_sel | input | 1 | Receive and status served by DMA |
| hold_wr | input | 1 | Holding register write strobe |
| shift_load | input | 1 | Shifter requests a load from the holding register |
| shift_empty | input | 1 | Shift register idle |
| rx_done | input | 1 | Received word moved to the data register |
| rx_read | input | 1 | Receive data register read |
| wake_evt | input | 1 | Receive line activity wakeup event |
| wake_clr | input | 1 | Write-1 clear of the wakeup flag |
| txrdy | output | 1 | Transmit-ready flag |
| tx_empty | output | 1 | Holding and shift registers both empty |
| rxrdy | output | 1 | Receive-ready flag |
| wake_flag | output | 1 | Wakeup flag |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| vec0 | output | VEC_W | Line 0 vector |
| vec1 | output | VEC_W | Line 1 vector |

## Verification
A wrong holding-register state shows at `tx_empty` in the cycle after the event. It also shows at `txrdy` at the next `shift_load`. A bad enable, routing or DMA gate leaves a flag visible without a request, and that shows as a wrong line or vector exactly one cycle after the flag changes. A priority error only appears when two sources share a line, so stimulus must pile several pending sources onto one line and then remove them one at a time.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;
  localparam int unsigned SRC_N    = 3;
  localparam int unsigned SRC_WAKE = 0;
  localparam int unsigned SRC_RX   = 1;
  localparam int unsigned SRC_TX   = 2;

  // vector of lowest set request: index+1, 0 when none
  function automatic int unsigned lowest_vec(input logic [SRC_N-1:0] m);
    int unsigned r;
    r = 0;
    for (int i = int'(SRC_N) - 1; i >= 0; i--) begin
      if (m[i]) r = i + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sp_flag_cell.sv
module sp_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d;

  generate
    if (SET_WINS) begin : g_set_wins
      assign d = set | (q & ~clr);
    end else begin : g_clr_wins
      assign d = ~clr & (set | q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (flush) q <= 1'b0;
    else            q <= d;
  end
endmodule

// File: rtl/sp_tx_track.sv
module sp_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_reset,
  input  logic tx_enable,
  input  logic hold_wr,
  input  logic shift_load,
  input  logic shift_empty,
  output logic hold_full,
  output logic xfer,
  output logic txrdy,
  output logic tx_empty
);
  logic flush;

  assign flush    = soft_reset | ~tx_enable;
  assign xfer     = shift_load & hold_full;
  assign tx_empty = ~hold_full & shift_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      txrdy     <= 1'b0;
    end else if (flush) begin
      hold_full <= 1'b0;
      txrdy     <= 1'b0;
    end else if (hold_wr) begin
      hold_full <= 1'b1;
      txrdy     <= 1'b0;
    end else if (xfer) begin
      hold_full <= 1'b0;
      txrdy     <= 1'b1;
    end
  end
endmodule

// File: rtl/sp_prio_enc.sv
module sp_prio_enc
  import sp_irq_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req,
  output logic             line_q,
  output logic [VEC_W-1:0] vec_q
);
  logic [VEC_W-1:0] vec_d;

  assign vec_d = VEC_W'(lowest_vec(req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      line_q <= |req;
      vec_q  <= vec_d;
    end
  end
endmodule

// File: rtl/sp_irq_flags.sv
module sp_irq_flags
  import sp_irq_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_reset,
  input  logic             tx_enable,
  input  logic [SRC_N-1:0] ien_set,
  input  logic [SRC_N-1:0] ien_clr,
  input  logic [SRC_N-1:0] lvl_sel,
  input  logic             tx_dma_sel,
  input  logic             rx_dma_sel,
  input  logic             rx_dma_all_sel,
  input  logic             hold_wr,
  input  logic             shift_load,
  input  logic             shift_empty,
  input  logic             rx_done,
  input  logic             rx_read,
  input  logic             wake_evt,
  input  logic             wake_clr,
  output logic             txrdy,
  output logic             tx_empty,
  output logic             rxrdy,
  output logic             wake_flag,
  output logic             irq0,
  output logic             irq1,
  output logic [VEC_W-1:0] vec0,
  output logic [VEC_W-1:0] vec1
);
  localparam int unsigned LINES = 2;

  logic                         hold_full;
  logic                         xfer;
  logic [SRC_N-1:0]             en;
  logic [SRC_N-1:0]             pend;
  logic [LINES-1:0][SRC_N-1:0]  route;
  logic [LINES-1:0]             line;
  logic [LINES-1:0][VEC_W-1:0]  vec;

  sp_tx_track u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_reset (soft_reset),
    .tx_enable  (tx_enable),
    .hold_wr    (hold_wr),
    .shift_load (shift_load),
    .shift_empty(shift_empty),
    .hold_full  (hold_full),
    .xfer       (xfer),
    .txrdy      (txrdy),
    .tx_empty   (tx_empty)
  );

  sp_flag_cell #(.SET_WINS(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(soft_reset),
    .set(rx_done), .clr(rx_read), .q(rxrdy)
  );

  sp_flag_cell #(.SET_WINS(1'b1)) u_wake (
    .clk(clk), .rst_n(rst_n), .flush(soft_reset),
    .set(wake_evt), .clr(wake_clr), .q(wake_flag)
  );

  generate
    for (genvar i = 0; i < int'(SRC_N); i++) begin : g_en
      sp_flag_cell #(.SET_WINS(1'b0)) u_en (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .set(ien_set[i]), .clr(ien_clr[i]), .q(en[i])
      );
    end
  endgenerate

  assign pend[SRC_WAKE] = wake_flag & en[SRC_WAKE];
  assign pend[SRC_RX]   = rxrdy & en[SRC_RX] & ~rx_dma_sel & ~rx_dma_all_sel;
  assign pend[SRC_TX]   = txrdy & en[SRC_TX] & ~tx_dma_sel;

  generate
    for (genvar g = 0; g < int'(LINES); g++) begin : g_line
      if (g == 0) begin : g_lo
        assign route[g] = pend & ~lvl_sel;
      end else begin : g_hi
        assign route[g] = pend & lvl_sel;
      end
      sp_prio_enc #(.VEC_W(VEC_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (route[g]),
        .line_q(line[g]),
        .vec_q (vec[g])
      );
    end
  endgenerate

  assign irq0 = line[0];
  assign irq1 = line[1];
  assign vec0 = vec[0];
  assign vec1 = vec[1];
endmodule

// File: rtl/sp_irq_flags_chk.sv
module sp_irq_flags_chk
  import sp_irq_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_reset,
  input logic             tx_enable,
  input logic             hold_wr,
  input logic             shift_load,
  input logic             shift_empty,
  input logic             rx_done,
  input logic             wake_evt,
  input logic             hold_full,
  input logic             xfer,
  input logic             txrdy,
  input logic             tx_empty,
  input logic             rxrdy,
  input logic             wake_flag,
  input logic             irq0,
  input logic             irq1,
  input logic [VEC_W-1:0] vec0,
  input logic [VEC_W-1:0] vec1
);
  a_r2_txrdy_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hold_wr && tx_enable && !soft_reset) |=> txrdy);

  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !txrdy);

  a_r3_empty_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> shift_empty);

  a_r3_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && tx_enable && !soft_reset) |=> (hold_full && !tx_empty));

  a_r6_soft_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (!txrdy && !rxrdy && !wake_flag && !hold_full));

  a_r6_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (!txrdy && !hold_full));

  a_r7_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !soft_reset) |=> rxrdy);

  a_r8_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !soft_reset) |=> wake_flag);

  a_r11_vec0_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 == (vec0 != '0));

  a_r11_vec1_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 == (vec1 != '0));

  a_r11_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (vec0 <= VEC_W'(SRC_N)) && (vec1 <= VEC_W'(SRC_N)));
endmodule

bind sp_irq_flags sp_irq_flags_chk #(.VEC_W(VEC_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_reset (soft_reset),
  .tx_enable  (tx_enable),
  .hold_wr    (hold_wr),
  .shift_load (shift_load),
  .shift_empty(shift_empty),
  .rx_done    (rx_done),
  .wake_evt   (wake_evt),
  .hold_full  (hold_full),
  .xfer       (xfer),
  .txrdy      (txrdy),
  .tx_empty   (tx_empty),
  .rxrdy      (rxrdy),
  .wake_flag  (wake_flag),
  .irq0       (irq0),
  .irq1       (irq1),
  .vec0       (vec0),
  .vec1       (vec1)
);

// File: tb/test_sp_irq_flags.sv
`timescale 1ns/100ps
module test_sp_irq_flags;
  localparam int VW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_reset = 0, tx_enable = 0, tx_dma_sel = 0, rx_dma_sel = 0, rx_dma_all_sel = 0;
  logic hold_wr = 0, shift_load = 0, shift_empty = 0, rx_done = 0, rx_read = 0;
  logic wake_evt = 0, wake_clr = 0;
  logic [2:0] ien_set = 0, ien_clr = 0, lvl_sel = 0;
  logic txrdy, tx_empty, rxrdy, wake_flag, irq0, irq1;
  logic [VW-1:0] vec0, vec1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  bit m_hold, m_txrdy, m_rx, m_wake, m_irq0, m_irq1;
  bit [2:0] m_en;
  int m_vec0, m_vec1;

  always #2.5 clk = ~clk;

  sp_irq_flags #(.VEC_W(VW)) i_sp_irq_flags (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .tx_enable(tx_enable),
    .ien_set(ien_set), .ien_clr(ien_clr), .lvl_sel(lvl_sel),
    .tx_dma_sel(tx_dma_sel), .rx_dma_sel(rx_dma_sel), .rx_dma_all_sel(rx_dma_all_sel),
    .hold_wr(hold_wr), .shift_load(shift_load), .shift_empty(shift_empty),
    .rx_done(rx_done), .rx_read(rx_read), .wake_evt(wake_evt), .wake_clr(wake_clr),
    .txrdy(txrdy), .tx_empty(tx_empty), .rxrdy(rxrdy), .wake_flag(wake_flag),
    .irq0(irq0), .irq1(irq1), .vec0(vec0), .vec1(vec1)
  );

  function automatic int pick(input bit [2:0] m);
    for (int i = 0; i < 3; i++) if (m[i]) return i + 1;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit [2:0] p;
    bit xf;
    p[0] = m_wake & m_en[0];
    p[1] = m_rx & m_en[1] & ~rx_dma_sel & ~rx_dma_all_sel;
    p[2] = m_txrdy & m_en[2] & ~tx_dma_sel;
    m_irq0 = |(p & ~lvl_sel);
    m_irq1 = |(p & lvl_sel);
    m_vec0 = pick(p & ~lvl_sel);
    m_vec1 = pick(p & lvl_sel);
    if (soft_reset || !tx_enable) begin
      m_hold = 0; m_txrdy = 0;
    end else begin
      xf = shift_load & m_hold;
      if (hold_wr) begin m_hold = 1; m_txrdy = 0; end
      else if (xf) begin m_hold = 0; m_txrdy = 1; end
    end
    if (soft_reset) m_rx = 0; else if (rx_done) m_rx = 1; else if (rx_read) m_rx = 0;
    if (soft_reset) m_wake = 0; else if (wake_evt) m_wake = 1; else if (wake_clr) m_wake = 0;
    m_en = (m_en | ien_set) & ~ien_clr;
  endtask

  task automatic compare_all();
    chk("R2 txrdy", int'(txrdy), int'(m_txrdy));
    chk("R3 tx_empty", int'(tx_empty), int'(~m_hold & shift_empty));
    chk("R7 rxrdy", int'(rxrdy), int'(m_rx));
    chk("R8 wake_flag", int'(wake_flag), int'(m_wake));
    chk("R10 irq0", int'(irq0), int'(m_irq0));
    chk("R10 irq1", int'(irq1), int'(m_irq1));
    chk("R11 vec0", int'(vec0), m_vec0);
    chk("R11 vec1", int'(vec1), m_vec1);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    hold_wr = 0; shift_load = 0; rx_done = 0; rx_read = 0;
    wake_evt = 0; wake_clr = 0; ien_set = 0; ien_clr = 0; soft_reset = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    shift_empty = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txrdy", int'(txrdy), 0);
    chk("R1 rxrdy", int'(rxrdy), 0);
    chk("R1 wake", int'(wake_flag), 0);
    chk("R1 irq", int'({irq1, irq0}), 0);
    chk("R1 vec", int'(vec0) + int'(vec1), 0);
    chk("R1 tx_empty", int'(tx_empty), 1);
    rst_n = 1;
    m_hold = 0; m_txrdy = 0; m_rx = 0; m_wake = 0; m_en = 0;
    m_irq0 = 0; m_irq1 = 0; m_vec0 = 0; m_vec1 = 0;
    @(negedge clk);
    tx_enable = 1;
    step();

    // R4: enabling alone raises nothing
    ien_set = 3'b100; step(); idle();
    shift_load = 1; step(); shift_load = 0;
    step(); step();
    chk("R4 no irq before first transfer", int'(irq0), 0);
    hold_wr = 1; step(); hold_wr = 0;
    chk("R3 holding full", int'(tx_empty), 0);
    shift_load = 1; step(); shift_load = 0;
    chk("R2 txrdy after transfer", int'(txrdy), 1);
    step();
    chk("R4 irq after transfer", int'(irq0), 1);
    chk("R11 tx vector", int'(vec0), 3);

    // R5: suspend and re-arm
    ien_clr = 3'b100; step(); idle(); step();
    chk("R5 suspended", int'(irq0), 0);
    ien_set = 3'b100; step(); idle(); step();
    chk("R5 re-armed", int'(irq0), 1);
    tx_dma_sel = 1; step(); step();
    chk("R5 dma blocks", int'(irq0), 0);
    tx_dma_sel = 0;

    // R6: transmitter off
    tx_enable = 0; step(); tx_enable = 1;
    chk("R6 txrdy dropped", int'(txrdy), 0);
    step();
    chk("R6 irq dropped", int'(irq0), 0);

    // R9: clear wins over set
    wake_evt = 1; ien_set = 3'b001; ien_clr = 3'b001; step(); idle(); step();
    chk("R9 clear wins", int'(irq0), 0);

    // R10/R11: wake and rx share line 1
    lvl_sel = 3'b011; ien_set = 3'b011; rx_done = 1; step(); idle(); step();
    chk("R10 line1 high", int'(irq1), 1);
    chk("R11 wake wins", int'(vec1), 1);
    wake_clr = 1; step(); idle(); step();
    chk("R11 rx next", int'(vec1), 2);
    rx_dma_all_sel = 1; step(); step();
    chk("R7 dma-all blocks", int'(irq1), 0);
    rx_dma_all_sel = 0;
    soft_reset = 1; step(); idle();
    chk("R6 soft flush rx", int'(rxrdy), 0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      soft_reset     = ($urandom % 64) == 0;
      tx_enable      = ($urandom % 32) != 0;
      tx_dma_sel     = ($urandom % 8) == 0;
      rx_dma_sel     = ($urandom % 8) == 0;
      rx_dma_all_sel = ($urandom % 8) == 0;
      hold_wr        = ($urandom % 4) == 0;
      shift_load     = ($urandom % 3) == 0;
      shift_empty    = ($urandom % 2) == 0;
      rx_done        = ($urandom % 5) == 0;
      rx_read        = ($urandom % 4) == 0;
      wake_evt       = ($urandom % 9) == 0;
      wake_clr       = ($urandom % 6) == 0;
      ien_set        = 3'($urandom) & 3'($urandom);
      ien_clr        = 3'($urandom) & 3'($urandom) & 3'($urandom);
      lvl_sel        = ($urandom % 8) == 0 ? 3'($urandom) : lvl_sel;
      step();
    end
    idle();
    step();
    report();
  end
endmodule